// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

An eight-bit interrupt request register collects the event pulses and the buffer-status levels of eight peripheral sources. A processor reaches it over a small register bus. The bus has a write strobe, one address bit and separate write and read data buses. Address 0 selects the flag register and address 1 selects the companion enable register. The combined interrupt request is high when the global enable input is high and at least one flag has its enable bit set.

There are two kinds of flag. Six flags record events and hold their value until software writes 0 to them: the parallel-port access, converter done, serial transfer complete, capture/compare, timer2 period match and timer1 overflow flags. The receive-full flag and the transmit-empty flag do not hold a value of their own. Each one follows the level of its buffer-status input, so the peripheral clears it when that buffer is read or written. A flag is set whether or not any enable is on, so software can poll the register with interrupts masked. A build-time parameter removes the parallel-port flag.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset both registers read 0x00 when rx_full_i and tx_empty_i are low, and irq_o is low. Flag bit positions: 7 parallel port, 6 converter, 5 receive full, 4 transmit empty, 3 serial port, 2 capture/compare, 1 timer2, 0 timer1.
- R2: An event pulse on a sticky source sets its flag on the next clock edge. This happens with the matching enable bit and gie_i at any value.
- R3: A sticky flag stays at 1 until a write to address 0 carries 0 in its bit position. That write clears it on the next edge.
- R4: A write to address 0 with 1 in a sticky flag's position sets that flag.
- R5: Bit 5 of the flag register equals rx_full_i at all times. Writes to bit 5 have no effect.
- R6: Bit 4 of the flag register equals tx_empty_i at all times. Writes to bit 4 have no effect.
- R7: The capture/compare flag (bit 2) is set by a capture pulse or by a compare pulse. While ccp_pwm_mode_i is high, neither pulse sets it.
- R8: With HAS_PPORT = 0, bit 7 of the flag register always reads 0. Neither the parallel-port pulse nor a bus write changes it.
- R9: When an event pulse and a write of 0 to the same flag fall in the same cycle, the flag ends up at 1.
- R10: irq_o is high exactly when gie_i is high and some bit is 1 in both the flag register and the enable register.
- R11: The enable register is written and read at address 1. All eight of its bits are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 flags, 1 enables |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| ev_pport_i | input | 1 | Parallel-port access pulse |
| ev_adc_i | input | 1 | Converter done pulse |
| ev_ssp_i | input | 1 | Serial transfer complete pulse |
| ev_capture_i | input | 1 | Capture event pulse |
| ev_compare_i | input | 1 | Compare match pulse |
| ccp_pwm_mode_i | input | 1 | Capture/compare unit is in PWM mode |
| ev_tmr2_i | input | 1 | Timer2 period match pulse |
| ev_tmr1_i | input | 1 | Timer1 overflow pulse |
| rx_full_i | input | 1 | Receive buffer holds data |
| tx_empty_i | input | 1 | Transmit buffer is empty |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Single and grouped event pulses are applied with every enable off. This separates flags that latch from flags that only pass a pulse through. Writes carry patterns that mix 1s and 0s across sticky and status bits, so set-by-write, clear-by-write and ignored bits show up in the same readback. Two cases test precedence: an event pulse in the same cycle as a clearing write, and capture or compare pulses in PWM mode. A second instance built without the parallel-port flag gets the same stimulus, and its readback is compared with the full instance.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int NUM_FLAGS = 8;
  localparam int BIT_PPORT = 7;
  localparam int BIT_ADC   = 6;
  localparam int BIT_RX    = 5;
  localparam int BIT_TX    = 4;
  localparam int BIT_SSP   = 3;
  localparam int BIT_CCP   = 2;
  localparam int BIT_TMR2  = 1;
  localparam int BIT_TMR1  = 0;
  localparam logic [NUM_FLAGS-1:0] STICKY_MASK = 8'b1100_1111;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);
  // event has priority over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (wr_i)  q_o <= wbit_i;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/irq_req_combine.sv
module irq_req_combine #(
  parameter int W = 8
) (
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] en_i,
  input  logic         gie_i,
  output logic         irq_o
);
  assign irq_o = gie_i & (|(flags_i & en_i));
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
#(
  parameter bit HAS_PPORT = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 addr_i,
  input  logic [NUM_FLAGS-1:0] wdata_i,
  output logic [NUM_FLAGS-1:0] rdata_o,
  input  logic                 ev_pport_i,
  input  logic                 ev_adc_i,
  input  logic                 ev_ssp_i,
  input  logic                 ev_capture_i,
  input  logic                 ev_compare_i,
  input  logic                 ccp_pwm_mode_i,
  input  logic                 ev_tmr2_i,
  input  logic                 ev_tmr1_i,
  input  logic                 rx_full_i,
  input  logic                 tx_empty_i,
  input  logic                 gie_i,
  output logic                 irq_o
);
  localparam flag_vec_t KEEP_MASK =
    HAS_PPORT ? STICKY_MASK : (STICKY_MASK & ~(flag_vec_t'(1) << BIT_PPORT));

  flag_vec_t ev_vec;
  flag_vec_t flag_q;
  flag_vec_t en_q;
  logic      wr_flags;
  logic      wr_en;

  assign wr_flags = we_i & ~addr_i;
  assign wr_en    = we_i &  addr_i;

  always_comb begin
    ev_vec            = '0;
    ev_vec[BIT_PPORT] = ev_pport_i;
    ev_vec[BIT_ADC]   = ev_adc_i;
    ev_vec[BIT_SSP]   = ev_ssp_i;
    ev_vec[BIT_CCP]   = (ev_capture_i | ev_compare_i) & ~ccp_pwm_mode_i;
    ev_vec[BIT_TMR2]  = ev_tmr2_i;
    ev_vec[BIT_TMR1]  = ev_tmr1_i;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    if (KEEP_MASK[i]) begin : g_sticky
      irq_sticky_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (ev_vec[i]),
        .wr_i   (wr_flags),
        .wbit_i (wdata_i[i]),
        .q_o    (flag_q[i])
      );
    end else if (i == BIT_RX) begin : g_rx
      assign flag_q[i] = rx_full_i;
    end else if (i == BIT_TX) begin : g_tx
      assign flag_q[i] = tx_empty_i;
    end else begin : g_absent
      assign flag_q[i] = 1'b0;
    end
  end

  irq_enable_reg #(.W(NUM_FLAGS)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en),
    .wdata_i (wdata_i),
    .q_o     (en_q)
  );

  irq_req_combine #(.W(NUM_FLAGS)) u_comb (
    .flags_i (flag_q),
    .en_i    (en_q),
    .gie_i   (gie_i),
    .irq_o   (irq_o)
  );

  assign rdata_o = addr_i ? en_q : flag_q;
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk #(
  parameter bit HAS_PPORT = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic       addr_i,
  input logic [7:0] wdata_i,
  input logic       ev_adc_i,
  input logic       ev_capture_i,
  input logic       ev_compare_i,
  input logic       ccp_pwm_mode_i,
  input logic       ev_tmr1_i,
  input logic       rx_full_i,
  input logic       tx_empty_i,
  input logic       gie_i,
  input logic [7:0] flag_q,
  input logic [7:0] en_q,
  input logic       irq_o
);
  logic wr_f;
  assign wr_f = we_i && !addr_i;

  a_r2_adc_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_adc_i |=> flag_q[6]);

  a_r3_tmr1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q[0] && !(wr_f && !wdata_i[0]) |=> flag_q[0]);

  a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_tmr1_i && wr_f && !wdata_i[0] |=> flag_q[0]);

  a_r7_pwm_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccp_pwm_mode_i && (ev_capture_i || ev_compare_i) && !flag_q[2]
      && !(wr_f && wdata_i[2]) |=> !flag_q[2]);

  a_r5_rx_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q[5] == rx_full_i);

  a_r6_tx_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q[4] == tx_empty_i);

  a_r10_gie_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);

  a_r10_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & en_q) == 8'h00) |-> !irq_o);

  if (!HAS_PPORT) begin : g_np
    a_r8_pport_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flag_q[7]);
  end
endmodule

bind irq_flag_reg irq_flag_chk #(.HAS_PPORT(HAS_PPORT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .ev_adc_i       (ev_adc_i),
  .ev_capture_i   (ev_capture_i),
  .ev_compare_i   (ev_compare_i),
  .ccp_pwm_mode_i (ccp_pwm_mode_i),
  .ev_tmr1_i      (ev_tmr1_i),
  .rx_full_i      (rx_full_i),
  .tx_empty_i     (tx_empty_i),
  .gie_i          (gie_i),
  .flag_q         (flag_q),
  .en_q           (en_q),
  .irq_o          (irq_o)
);

// File: tb/irq_flag_reg_test.sv
`timescale 1ns/1ps
module irq_flag_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, rdata_np;
  logic       ev_pport = 0, ev_adc = 0, ev_ssp = 0, ev_cap = 0, ev_cmp = 0;
  logic       pwm = 0, ev_tmr2 = 0, ev_tmr1 = 0, rx_full = 0, tx_empty = 0, gie = 0;
  logic       irq, irq_np;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_flag_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ev_pport_i(ev_pport), .ev_adc_i(ev_adc), .ev_ssp_i(ev_ssp),
    .ev_capture_i(ev_cap), .ev_compare_i(ev_cmp), .ccp_pwm_mode_i(pwm),
    .ev_tmr2_i(ev_tmr2), .ev_tmr1_i(ev_tmr1), .rx_full_i(rx_full),
    .tx_empty_i(tx_empty), .gie_i(gie), .irq_o(irq));

  irq_flag_reg #(.HAS_PPORT(1'b0)) uut_np (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_np), .ev_pport_i(ev_pport), .ev_adc_i(ev_adc), .ev_ssp_i(ev_ssp),
    .ev_capture_i(ev_cap), .ev_compare_i(ev_cmp), .ccp_pwm_mode_i(pwm),
    .ev_tmr2_i(ev_tmr2), .ev_tmr1_i(ev_tmr1), .rx_full_i(rx_full),
    .tx_empty_i(tx_empty), .gie_i(gie), .irq_o(irq_np));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata; addr = 1'b0;
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b0, d); chk("R1 flags after reset", d, 8'h00);
    rd(1'b1, d); chk("R1 enables after reset", d, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_events;
    logic [7:0] d;
    @(negedge clk); ev_adc = 1; @(negedge clk); ev_adc = 0;
    rd(1'b0, d); chk("R2 converter event with enables off", d, 8'h40);
    @(negedge clk); ev_tmr1 = 1; ev_tmr2 = 1; ev_ssp = 1;
    @(negedge clk); ev_tmr1 = 0; ev_tmr2 = 0; ev_ssp = 0;
    rd(1'b0, d); chk("R2 grouped events", d, 8'h4B);
    settle; settle;
    rd(1'b0, d); chk("R3 flags hold after pulses", d, 8'h4B);
    bus_wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R3 write 0 clears converter only", d, 8'h0B);
    bus_wr(1'b0, 8'h00);
    rd(1'b0, d); chk("R3 write 0 clears all", d, 8'h00);
  endtask

  task automatic t_swset;
    logic [7:0] d;
    bus_wr(1'b0, 8'hFF);
    rd(1'b0, d); chk("R4/R5/R6 write 1 sets sticky only", d, 8'hCF);
    bus_wr(1'b0, 8'h30);
    rd(1'b0, d); chk("R3 write 0x30 clears sticky", d, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] d;
    @(negedge clk); rx_full = 1; #1;
    rd(1'b0, d); chk("R5 receive full tracks", d, 8'h20);
    tx_empty = 1; #1;
    rd(1'b0, d); chk("R6 transmit empty tracks", d, 8'h30);
    bus_wr(1'b0, 8'h00);
    rd(1'b0, d); chk("R5 write ignored on status bits", d, 8'h30);
    rx_full = 0; #1;
    rd(1'b0, d); chk("R5 receive flag clears with buffer", d, 8'h10);
    tx_empty = 0; #1;
    rd(1'b0, d); chk("R6 transmit flag clears with buffer", d, 8'h00);
  endtask

  task automatic t_ccp;
    logic [7:0] d;
    @(negedge clk); ev_cap = 1; @(negedge clk); ev_cap = 0;
    rd(1'b0, d); chk("R7 capture sets flag", d, 8'h04);
    bus_wr(1'b0, 8'h00);
    @(negedge clk); ev_cmp = 1; @(negedge clk); ev_cmp = 0;
    rd(1'b0, d); chk("R7 compare sets flag", d, 8'h04);
    bus_wr(1'b0, 8'h00);
    @(negedge clk); pwm = 1; ev_cap = 1; ev_cmp = 1;
    @(negedge clk); ev_cap = 0; ev_cmp = 0;
    rd(1'b0, d); chk("R7 no set in PWM mode", d, 8'h00);
    pwm = 0;
  endtask

  task automatic t_race;
    logic [7:0] d;
    @(negedge clk); ev_tmr1 = 1; @(negedge clk); ev_tmr1 = 0;
    @(negedge clk); we = 1; addr = 0; wdata = 8'h00; ev_tmr1 = 1; ev_adc = 0;
    @(negedge clk); we = 0; ev_tmr1 = 0;
    rd(1'b0, d); chk("R9 event beats clearing write", d, 8'h01);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    bus_wr(1'b1, 8'h40);
    rd(1'b1, d); chk("R11 enable readback", d, 8'h40);
    gie = 1; #1;
    chk("R10 no flag no irq", {7'd0, irq}, 8'h00);
    @(negedge clk); ev_adc = 1; @(negedge clk); ev_adc = 0;
    chk("R10 enabled flag raises irq", {7'd0, irq}, 8'h01);
    gie = 0; #1;
    chk("R10 gie low masks irq", {7'd0, irq}, 8'h00);
    gie = 1;
    bus_wr(1'b1, 8'h20);
    chk("R10 flag without enable", {7'd0, irq}, 8'h00);
    rx_full = 1; #1;
    chk("R10 status flag raises irq", {7'd0, irq}, 8'h01);
    rx_full = 0; gie = 0;
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_nopport;
    logic [7:0] d;
    @(negedge clk); ev_pport = 1; @(negedge clk); ev_pport = 0;
    rd(1'b0, d); chk("R2 parallel-port flag set", d, 8'h80);
    chk("R8 removed flag ignores event", rdata_np, 8'h00);
    bus_wr(1'b0, 8'h80);
    chk("R8 removed flag ignores write", rdata_np, 8'h00);
    bus_wr(1'b0, 8'h00);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_events;
    t_swset;
    t_status;
    t_ccp;
    t_race;
    t_irq;
    t_nopport;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule